// File: doc/BRIEF.md
# Host-side receive endpoint status logic

This block holds the control and status state for one receive endpoint of a USB host controller. A protocol engine reports transaction outcomes as single-cycle event pulses: a clean data packet, a data packet that arrived with a CRC or bit-stuff fault, a NAK handshake, or an attempt that got no answer. The block models a receive buffer with two packet slots. It tracks only slot occupancy and a per-slot fault flag, because packet bytes live elsewhere. The 5-bit status word gives the CPU a packet-ready flag, a buffer-full flag, a retry-exhausted error, a mode-dependent fault/timeout flag and a flush command.

The meaning of the status word depends on the selected transfer type. In isochronous mode, faulty packets are still delivered, and each one carries its fault flag with it through the buffer. In bulk and interrupt modes, faulty packets and silent attempts count toward a three-strike error. In bulk mode only, a run of NAKs that lasts longer than a programmable number of frame ticks halts the endpoint. The error and the timeout stay latched until software writes 0 to them. Flushing or acknowledging removes one buffered packet at a time.

Top module: `usb_host_rx_ep_status`

## Requirements
- R1: After a synchronous reset, the status word reads 00000, `irq_o` is low and `attempt_en_o` is high.
- R2: A data packet that arrives while a slot is free is stored. This covers a clean packet in any mode, or a faulty packet in isochronous mode. Status bit 0 (packet ready) is high while at least one packet is stored. `irq_o` is high while bit 0 or bit 2 reads 1.
- R3: A write with bit 0 = 0 or bit 4 = 1 removes exactly one stored packet, even when both apply in the same write. It has no effect when nothing is stored. Writing 1 to bit 0 removes nothing, and bit 4 always reads 0.
- R4: Status bit 1 reads 1 exactly when both slots are occupied. A packet that arrives while both slots are occupied is dropped.
- R5: In isochronous mode (mode code 00), bit 3 reads the fault flag of the oldest stored packet. The flag leaves together with that packet.
- R6: In bulk (01) and interrupt (10 or 11) modes, three no-response events or faulty packets with no clean packet in between set bit 2. A clean packet restarts the count. A write with bit 2 = 0 clears the bit and the count. In isochronous mode, bit 2 reads 0 and nothing is counted.
- R7: In bulk mode, after a NAK, the `nak_limit_i`-th frame tick with no data packet in between sets bit 3, which then stays set. A data packet restarts the timer, and so does a write with bit 3 = 0, which also clears the bit. Writing 1 to bit 3 has no effect, and no timeout forms in the other modes.
- R8: `attempt_en_o` is low while bit 2 is set, or while a bulk NAK timeout is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Transfer type: 00 isochronous, 01 bulk, 10/11 interrupt |
| nak_limit_i | input | TICK_W | NAK timeout length in frame ticks (0 disables) |
| tick_i | input | 1 | Frame tick pulse |
| ev_pkt_ok_i | input | 1 | Clean data packet received |
| ev_pkt_bad_i | input | 1 | Data packet with CRC or bit-stuff fault received |
| ev_nak_i | input | 1 | NAK handshake received |
| ev_noresp_i | input | 1 | Attempt ended with no response |
| wr_en_i | input | 1 | CPU write strobe to the status word |
| wr_data_i | input | 5 | CPU write data |
| rd_data_o | output | 5 | Status word: {flush, fault/timeout, error, full, ready} |
| irq_o | output | 1 | Interrupt request level |
| attempt_en_o | output | 1 | Engine may start new attempts |

## Verification
The bench flushes with a single packet and with two packets stored. A design that empties the whole buffer on one flush, or that counts a combined acknowledge-and-flush write as two removals, loses the second packet. Overfill is also exercised: a design that accepts a third packet corrupts occupancy or bit 1. In isochronous mode the first packet is faulty and the second is clean, so a design that keeps the fault flag in the register instead of in the slot still shows bit 3 after the acknowledge. The bench also places a clean packet between no-response events and in the middle of a NAK window. A design that forgets to restart either counter reports an error or a timeout too early. Finally, it writes 1 to latched bits, which a design must not treat as a clear.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;
  typedef enum logic [1:0] {
    XFER_ISO  = 2'b00,
    XFER_BULK = 2'b01,
    XFER_INTR = 2'b10,
    XFER_INT2 = 2'b11
  } xfer_mode_e;

  localparam int STAT_W    = 5;
  localparam int BIT_RDY   = 0;
  localparam int BIT_FULL  = 1;
  localparam int BIT_ERR   = 2;
  localparam int BIT_FAULT = 3;
  localparam int BIT_FLUSH = 4;
endpackage

// File: rtl/rx_slot_track.sv
module rx_slot_track #(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          fault_i,
  input  logic          pop_i,
  output logic [OW-1:0] occ_o,
  output logic          full_o,
  output logic          head_fault_o
);
  logic [DEPTH-1:0] fault_q;
  logic [PW-1:0]    wp_q, rp_q;
  logic [OW-1:0]    occ_q;
  logic             do_push, do_pop;

  assign full_o  = (occ_q == OW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (occ_q != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) fault_q[wp_q] <= fault_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      occ_q <= occ_q + OW'(do_push) - OW'(do_pop);
    end
  end

  assign occ_o        = occ_q;
  assign head_fault_o = (occ_q != '0) && fault_q[rp_q];

  AST_OCC_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    occ_q <= OW'(DEPTH)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0 && !push_i) |=> occ_q == '0); // R3
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (full_o && !pop_i) |=> full_o); // R4
endmodule

// File: rtl/rx_retry_count.sv
module rx_retry_count #(
  parameter int MAX_TRIES = 3,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic fail_i,
  input  logic data_i,
  input  logic clr_i,
  output logic err_o
);
  logic [CW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (data_i) begin
      cnt_q <= '0;
    end else if (en_i && fail_i && !err_q) begin
      if (cnt_q == CW'(MAX_TRIES - 1)) begin
        err_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;

  AST_ERR_ON_LAST_TRY: assert property (@(posedge clk) disable iff (rst)
    (en_i && fail_i && !err_q && !clr_i && !data_i && cnt_q == CW'(MAX_TRIES - 1))
      |=> err_q); // R6
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_i) |=> err_q); // R6
endmodule

// File: rtl/rx_nak_timer.sv
module rx_nak_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              nak_i,
  input  logic              tick_i,
  input  logic [TICK_W-1:0] limit_i,
  input  logic              data_i,
  input  logic              clr_i,
  output logic              to_o
);
  logic [TICK_W-1:0] cnt_q;
  logic              act_q, to_q;
  logic [TICK_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      to_q  <= 1'b0;
    end else if (data_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en_i) begin
      if (nak_i) act_q <= 1'b1;
      if (act_q && tick_i && !to_q) begin
        if (limit_i != '0 && cnt_inc >= {1'b0, limit_i}) to_q <= 1'b1;
        else cnt_q <= cnt_inc[TICK_W-1:0];
      end
    end
  end

  assign to_o = to_q;

  AST_TO_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (to_q && !clr_i) |=> to_q); // R7
  AST_TO_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (!to_q && !tick_i) |=> !to_q); // R7
  AST_TO_ONLY_BULK: assert property (@(posedge clk) disable iff (rst)
    (!to_q && !en_i) |=> !to_q); // R7
endmodule

// File: rtl/usb_host_rx_ep_status.sv
module usb_host_rx_ep_status
  import usb_rx_ep_pkg::*;
#(
  parameter int DEPTH     = 2,
  parameter int MAX_TRIES = 3,
  parameter int TICK_W    = 8,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [TICK_W-1:0] nak_limit_i,
  input  logic              tick_i,
  input  logic              ev_pkt_ok_i,
  input  logic              ev_pkt_bad_i,
  input  logic              ev_nak_i,
  input  logic              ev_noresp_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              attempt_en_o
);
  logic          is_iso, is_bulk;
  logic          pkt_in, pop, clr_err, clr_nak;
  logic [OW-1:0] occ;
  logic          full, head_fault, rdy, err, nak_to;

  assign is_iso  = (xfer_mode_e'(mode_i) == XFER_ISO);
  assign is_bulk = (xfer_mode_e'(mode_i) == XFER_BULK);

  // Faulty packets are delivered only in isochronous mode.
  assign pkt_in  = ev_pkt_ok_i || (ev_pkt_bad_i && is_iso);
  assign rdy     = (occ != '0);
  assign pop     = wr_en_i && rdy && (!wr_data_i[BIT_RDY] || wr_data_i[BIT_FLUSH]);
  assign clr_err = wr_en_i && !wr_data_i[BIT_ERR];
  assign clr_nak = wr_en_i && !wr_data_i[BIT_FAULT];

  rx_slot_track #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst(rst),
    .push_i(pkt_in), .fault_i(ev_pkt_bad_i), .pop_i(pop),
    .occ_o(occ), .full_o(full), .head_fault_o(head_fault)
  );

  rx_retry_count #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst(rst),
    .en_i(!is_iso), .fail_i(ev_noresp_i || ev_pkt_bad_i),
    .data_i(ev_pkt_ok_i), .clr_i(clr_err), .err_o(err)
  );

  rx_nak_timer #(.TICK_W(TICK_W)) u_nak (
    .clk(clk), .rst(rst),
    .en_i(is_bulk), .nak_i(ev_nak_i), .tick_i(tick_i), .limit_i(nak_limit_i),
    .data_i(pkt_in), .clr_i(clr_nak), .to_o(nak_to)
  );

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[BIT_RDY]   = rdy;
    rd_data_o[BIT_FULL]  = full;
    rd_data_o[BIT_ERR]   = err && !is_iso;
    rd_data_o[BIT_FAULT] = is_iso ? head_fault : nak_to;
  end

  assign irq_o        = rdy || (err && !is_iso);
  assign attempt_en_o = !err && !(is_bulk && nak_to);

  AST_PKT_SETS_RDY: assert property (@(posedge clk) disable iff (rst)
    (pkt_in && !pop) |=> rd_data_o[BIT_RDY]); // R2
  AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[BIT_FLUSH] == 1'b0); // R3
  AST_IRQ_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[BIT_RDY] |-> irq_o); // R2
  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[BIT_ERR] |-> !attempt_en_o); // R8
endmodule

// File: tb/tb_usb_host_rx_ep_status.sv
module tb_usb_host_rx_ep_status;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic [7:0] nak_limit;
  logic       tick, ev_ok, ev_bad, ev_nak, ev_nr, we;
  logic [4:0] wd;
  logic [4:0] rd;
  logic       irq, aen;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  usb_host_rx_ep_status dut (
    .clk(clk), .rst(rst), .mode_i(mode), .nak_limit_i(nak_limit), .tick_i(tick),
    .ev_pkt_ok_i(ev_ok), .ev_pkt_bad_i(ev_bad), .ev_nak_i(ev_nak), .ev_noresp_i(ev_nr),
    .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq), .attempt_en_o(aen)
  );

  // {mode[2], events{noresp,nak,bad,ok}[4], wr_en, wr_data[5], exp_status[5], exp_irq}
  localparam logic [17:0] VEC [17] = '{
    {2'b01, 4'b0000, 1'b0, 5'b00000, 5'b00000, 1'b0}, // R2 idle
    {2'b01, 4'b0001, 1'b0, 5'b00000, 5'b00001, 1'b1}, // R2 first packet
    {2'b01, 4'b0001, 1'b0, 5'b00000, 5'b00011, 1'b1}, // R4 second fills
    {2'b01, 4'b0001, 1'b0, 5'b00000, 5'b00011, 1'b1}, // R4 dropped when full
    {2'b01, 4'b0000, 1'b1, 5'b00000, 5'b00001, 1'b1}, // R3 ack pops one
    {2'b01, 4'b0000, 1'b1, 5'b10001, 5'b00000, 1'b0}, // R3 flush pops one
    {2'b01, 4'b0000, 1'b1, 5'b10001, 5'b00000, 1'b0}, // R3 flush when empty
    {2'b01, 4'b1000, 1'b0, 5'b00000, 5'b00000, 1'b0}, // R6 miss 1
    {2'b01, 4'b1000, 1'b0, 5'b00000, 5'b00000, 1'b0}, // R6 miss 2
    {2'b01, 4'b1000, 1'b0, 5'b00000, 5'b00100, 1'b1}, // R6 miss 3 sets error
    {2'b01, 4'b0000, 1'b1, 5'b00001, 5'b00000, 1'b0}, // R6 write 0 clears, R3 bit0=1 no pop
    {2'b00, 4'b0010, 1'b0, 5'b00000, 5'b01001, 1'b1}, // R5 faulty iso packet
    {2'b00, 4'b0001, 1'b0, 5'b00000, 5'b01011, 1'b1}, // R5 clean second packet
    {2'b00, 4'b0000, 1'b1, 5'b11110, 5'b00001, 1'b1}, // R3 ack+flush pops one, R5 flag leaves
    {2'b00, 4'b1000, 1'b0, 5'b00000, 5'b00001, 1'b1}, // R6 iso miss not counted
    {2'b10, 4'b0000, 1'b1, 5'b11100, 5'b00000, 1'b0}, // R3 flush in interrupt mode
    {2'b10, 4'b0010, 1'b0, 5'b00000, 5'b00000, 1'b0}  // R2 faulty packet not stored
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [3:0] ev, input logic tk,
                      input logic w, input logic [4:0] d);
    mode = m; {ev_nr, ev_nak, ev_bad, ev_ok} = ev; tick = tk; we = w; wd = d;
    @(posedge clk);
    @(negedge clk);
    {ev_nr, ev_nak, ev_bad, ev_ok} = '0; tick = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    mode = 2'b01; nak_limit = 8'd3; tick = 0; ev_ok = 0; ev_bad = 0; ev_nak = 0;
    ev_nr = 0; we = 0; wd = '0;
    @(negedge clk);
    do_reset();
    chk("R1 reset status", {1'b0, rd}, 6'b000000);
    chk("R1 reset irq/attempt", {4'b0, irq, aen}, 6'b000001);

    for (int i = 0; i < 17; i++) begin
      step(VEC[i][17:16], VEC[i][15:12], 1'b0, VEC[i][11], VEC[i][10:6]);
      chk($sformatf("vector %0d (see tag)", i), {rd, irq}, VEC[i][5:0]);
    end

    // R1: reset drops buffered packets
    step(2'b01, 4'b0001, 0, 0, 5'b0);
    do_reset();
    chk("R1 reset after packet", {rd, aen}, 6'b000001);

    // R6: a clean packet restarts the miss count; R8 halt
    step(2'b01, 4'b1000, 0, 0, 5'b0);
    step(2'b01, 4'b1000, 0, 0, 5'b0);
    step(2'b01, 4'b0001, 0, 0, 5'b0);
    step(2'b01, 4'b1000, 0, 0, 5'b0);
    step(2'b01, 4'b1000, 0, 0, 5'b0);
    chk("R6 count restarted by data", {1'b0, rd}, 6'b000001);
    step(2'b01, 4'b1000, 0, 0, 5'b0);
    chk("R6 third miss after data", {1'b0, rd}, 6'b000101);
    chk("R8 attempts blocked on error", {5'b0, aen}, 6'b000000);
    step(2'b01, 4'b0000, 0, 1, 5'b00101);
    chk("R6 write 1 keeps error", {1'b0, rd}, 6'b000101);
    step(2'b01, 4'b0000, 0, 1, 5'b00001);
    chk("R6 write 0 clears error", {rd, aen}, 6'b000011);

    // R7: bulk NAK timeout after limit ticks
    do_reset();
    step(2'b01, 4'b0100, 0, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    chk("R7 no timeout before limit", {rd, aen}, 6'b000001);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    chk("R7 timeout at limit", {1'b0, rd}, 6'b001000);
    chk("R8 attempts blocked on timeout", {5'b0, aen}, 6'b000000);
    step(2'b01, 4'b0000, 0, 1, 5'b01000);
    chk("R7 write 1 keeps timeout", {1'b0, rd}, 6'b001000);
    step(2'b01, 4'b0000, 0, 1, 5'b00000);
    chk("R7 write 0 clears timeout", {rd, aen}, 6'b000001);

    // R7: data packet restarts the window
    step(2'b01, 4'b0100, 0, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    step(2'b01, 4'b0001, 0, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    step(2'b01, 4'b0000, 1, 0, 5'b0);
    chk("R7 data restarts timer", {1'b0, rd}, 6'b000001);

    // R7: no timeout in interrupt mode
    do_reset();
    step(2'b10, 4'b0100, 0, 0, 5'b0);
    for (int k = 0; k < 5; k++) step(2'b10, 4'b0000, 1, 0, 5'b0);
    chk("R7 interrupt mode never times out", {rd, aen}, 6'b000001);

    // R5/R3: two faulty iso packets, two flushes empty
    do_reset();
    step(2'b00, 4'b0010, 0, 0, 5'b0);
    step(2'b00, 4'b0010, 0, 0, 5'b0);
    step(2'b00, 4'b0000, 0, 1, 5'b11111);
    chk("R5 second faulty packet flagged", {rd, irq}, 6'b010011);
    step(2'b00, 4'b0000, 0, 1, 5'b11111);
    chk("R3 second flush empties", {rd, irq}, 6'b000000);

    done = 1'b1;
    finish_run();
  end
endmodule